// File: doc/BRIEF.md
# BLDC Six-Step Commutation Sequencer

This block walks a three-phase bridge through a hold position and a six-step switching ring. Each commutation tick moves it one step. At every step it asks for exactly one low-side and one high-side switch, and it names the floating phase whose feedback should be sampled. The tick may come from a speed loop, an oscillator or a timer, provided it is synchronous to `clk`. The sequencer acts on the rising edge of the tick, so a tick held high for several cycles counts once.

After a synchronous reset the sequencer sits in a hold state that pins the rotor to a known angle. The first tick always moves it into the first ring step. The rotation direction is captured only while in the hold state, so the direction of a running motor cannot change until the next reset. No data stream passes through the block: every pin is a plain level control or status signal, and there is no back-pressure.

Top module: `bldc_step_seq`

## Requirements
- R1: While in the hold state, `lo_on` = 3'b010, `hi_on` = 3'b101 and `align` = 1. In both switch vectors, bit 0 is phase A, bit 1 is phase B and bit 2 is phase C.
- R2: The ring steps drive these switches (low, high, sampled phase): S0 = (C, A, B), S1 = (C, B, A), S2 = (A, B, C), S3 = (A, C, B), S4 = (B, C, A), S5 = (B, A, C).
- R3: `smp_sel` encodes the sampled phase as 2'b00 for A, 2'b01 for B and 2'b10 for C. It is 2'b11 (no phase) only in the hold state.
- R4: Outside the hold state, exactly one bit of `lo_on` and exactly one bit of `hi_on` are set, and the two bits belong to different phases.
- R5: The state changes only on the first cycle in which `tick` is high after a cycle in which it was low. It moves one step per rising edge, and the change is visible after that clock edge.
- R6: When `rst` is high at a clock edge, the next state is the hold state, whatever `tick` and `dir_fwd` are doing.
- R7: A tick rising edge in the hold state always enters S0, in either direction.
- R8: With forward selected (`dir_fwd` = 1), the order is S0, S1, S2, S3, S4, S5, and S5 wraps to S0.
- R9: With reverse selected (`dir_fwd` = 0), the order is S0, S5, S4, S3, S2, S1, and S1 wraps back to S0.
- R10: `dir_fwd` is captured only while in the hold state. A change to it after leaving the hold state has no effect until the next reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high, forces the hold state |
| tick | input | 1 | Commutation tick; each rising edge advances one step |
| dir_fwd | input | 1 | 1 selects forward order, 0 selects reverse |
| lo_on | output | 3 | Low-side switch requests, bit 0 = A, bit 1 = B, bit 2 = C |
| hi_on | output | 3 | High-side switch requests, same bit order |
| smp_sel | output | 2 | Floating phase to sample: 00 A, 01 B, 10 C, 11 none |
| align | output | 1 | High while in the hold state |

## Verification
The checker tests these properties on every cycle:
- the hold-state switch pattern and its no-sample code;
- one low-side and one high-side request on different phases in any running step;
- no output change in a cycle without a tick;
- entry into S0 from the hold state;
- the hold state after reset.

The order of the ring is left to the bench's directed scenarios. Those scenarios cover forward and reverse order with their wraps, a direction flip after start-up having no effect, a tick held high for several cycles, and a reset in the middle of a run.

// File: rtl/bldc_step_pkg.sv
package bldc_step_pkg;
  localparam int NUM_PH  = 3;
  localparam int SEL_W   = 2;
  localparam int NUM_STP = 6;
  localparam int ST_W    = $clog2(NUM_STP + 1);

  typedef enum logic [ST_W-1:0] {
    ST_S0 = 3'd0, ST_S1 = 3'd1, ST_S2 = 3'd2,
    ST_S3 = 3'd3, ST_S4 = 3'd4, ST_S5 = 3'd5,
    ST_HOLD = 3'd6
  } step_t;

  typedef struct packed {
    logic [NUM_PH-1:0] lo;
    logic [NUM_PH-1:0] hi;
    logic [SEL_W-1:0]  sel;
  } drive_t;

  localparam logic [SEL_W-1:0] SEL_A    = 2'b00;
  localparam logic [SEL_W-1:0] SEL_B    = 2'b01;
  localparam logic [SEL_W-1:0] SEL_C    = 2'b10;
  localparam logic [SEL_W-1:0] SEL_NONE = 2'b11;

  function automatic step_t step_after(step_t cur, logic fwd);
    step_t nxt;
    if (cur == ST_HOLD)     nxt = ST_S0;
    else if (fwd)           nxt = (cur == ST_S5) ? ST_S0 : step_t'(cur + 1'b1);
    else                    nxt = (cur == ST_S0) ? ST_S5 : step_t'(cur - 1'b1);
    return nxt;
  endfunction
endpackage

// File: rtl/bldc_tick_edge.sv
module bldc_tick_edge (
  input  logic clk,
  input  logic tick,
  output logic rise
);
  logic tick_q;

  // Tracks tick even in reset, so a tick held across reset does not count.
  always_ff @(posedge clk) tick_q <= tick;

  assign rise = tick & ~tick_q;
endmodule

// File: rtl/bldc_step_core.sv
module bldc_step_core
  import bldc_step_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  adv,
  input  logic  dir_fwd,
  output step_t state
);
  logic dir_q;
  logic dir_use;

  // The direction pin is used live in hold and frozen once running.
  assign dir_use = (state == ST_HOLD) ? dir_fwd : dir_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_HOLD;
      dir_q <= 1'b1;
    end else begin
      dir_q <= dir_use;
      if (adv) state <= step_after(state, dir_use);
    end
  end
endmodule

// File: rtl/bldc_step_decode.sv
module bldc_step_decode
  import bldc_step_pkg::*;
(
  input  step_t  state,
  output drive_t drv
);
  always_comb begin
    unique case (state)
      ST_S0:   drv = '{lo: 3'b100, hi: 3'b001, sel: SEL_B};
      ST_S1:   drv = '{lo: 3'b100, hi: 3'b010, sel: SEL_A};
      ST_S2:   drv = '{lo: 3'b001, hi: 3'b010, sel: SEL_C};
      ST_S3:   drv = '{lo: 3'b001, hi: 3'b100, sel: SEL_B};
      ST_S4:   drv = '{lo: 3'b010, hi: 3'b100, sel: SEL_A};
      ST_S5:   drv = '{lo: 3'b010, hi: 3'b001, sel: SEL_C};
      default: drv = '{lo: 3'b010, hi: 3'b101, sel: SEL_NONE};
    endcase
  end
endmodule

// File: rtl/bldc_step_seq.sv
module bldc_step_seq
  import bldc_step_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              dir_fwd,
  output logic [NUM_PH-1:0] lo_on,
  output logic [NUM_PH-1:0] hi_on,
  output logic [SEL_W-1:0]  smp_sel,
  output logic              align
);
  logic   adv;
  step_t  state;
  drive_t drv;

  bldc_tick_edge u_edge (
    .clk  (clk),
    .tick (tick),
    .rise (adv)
  );

  bldc_step_core u_core (
    .clk     (clk),
    .rst     (rst),
    .adv     (adv),
    .dir_fwd (dir_fwd),
    .state   (state)
  );

  bldc_step_decode u_dec (
    .state (state),
    .drv   (drv)
  );

  assign lo_on   = drv.lo;
  assign hi_on   = drv.hi;
  assign smp_sel = drv.sel;
  assign align   = (state == ST_HOLD);
endmodule

// File: rtl/bldc_step_seq_chk.sv
module bldc_step_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       tick,
  input logic [2:0] lo_on,
  input logic [2:0] hi_on,
  input logic [1:0] smp_sel,
  input logic       align
);
  AST_HOLD_PATTERN: assert property (@(posedge clk) disable iff (rst)
    align |-> (lo_on == 3'b010 && hi_on == 3'b101 && smp_sel == 2'b11)); // R1

  AST_SEL_RUNNING: assert property (@(posedge clk) disable iff (rst)
    !align |-> smp_sel != 2'b11); // R3

  AST_ONE_PAIR: assert property (@(posedge clk) disable iff (rst)
    !align |-> ($countones(lo_on) == 1 && $countones(hi_on) == 1
                && (lo_on & hi_on) == 3'b000)); // R4

  AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (rst)
    !tick |=> ($stable(lo_on) && $stable(hi_on) && $stable(smp_sel))); // R5

  AST_RESET_HOLD: assert property (@(posedge clk)
    rst |=> align); // R6

  AST_ENTER_S0: assert property (@(posedge clk) disable iff (rst)
    (align && tick && !$past(tick)) |=>
      (lo_on == 3'b100 && hi_on == 3'b001 && smp_sel == 2'b01)); // R7
endmodule

bind bldc_step_seq bldc_step_seq_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .tick    (tick),
  .lo_on   (lo_on),
  .hi_on   (hi_on),
  .smp_sel (smp_sel),
  .align   (align)
);

// File: tb/bldc_step_seq_tb.sv
module bldc_step_seq_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       dir_fwd = 1'b1;
  logic [2:0] lo_on, hi_on;
  logic [1:0] smp_sel;
  logic       align;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  bldc_step_seq u_dut (
    .clk(clk), .rst(rst), .tick(tick), .dir_fwd(dir_fwd),
    .lo_on(lo_on), .hi_on(hi_on), .smp_sel(smp_sel), .align(align)
  );

  // Expected outputs per step index (0..5 = S0..S5, 6 = hold).
  function automatic logic [8:0] expect_of(int idx);
    case (idx)
      0: return {1'b0, 3'b100, 3'b001, 2'b01};
      1: return {1'b0, 3'b100, 3'b010, 2'b00};
      2: return {1'b0, 3'b001, 3'b010, 2'b10};
      3: return {1'b0, 3'b001, 3'b100, 2'b01};
      4: return {1'b0, 3'b010, 3'b100, 2'b00};
      5: return {1'b0, 3'b010, 3'b001, 2'b10};
      default: return {1'b1, 3'b010, 3'b101, 2'b11};
    endcase
  endfunction

  task automatic check_step(string req, int idx);
    logic [8:0] got, exp;
    got = {align, lo_on, hi_on, smp_sel};
    exp = expect_of(idx);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: {align,lo,hi,sel} actual=%b expected=%b (step %0d)",
               req, got, exp, idx);
    end
  endtask

  task automatic do_reset(logic fwd);
    @(negedge clk); rst = 1'b1; dir_fwd = fwd;
    @(negedge clk);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic one_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic t_reset_state();
    do_reset(1'b1);
    check_step("R1", 6);
    check_step("R3", 6);
  endtask

  task automatic t_forward();
    do_reset(1'b1);
    one_tick();
    check_step("R7", 0);
    for (int i = 1; i <= 12; i++) begin
      one_tick();
      check_step((i % 6 == 0) ? "R8" : "R2", i % 6);
    end
  endtask

  task automatic t_reverse();
    do_reset(1'b0);
    one_tick();
    check_step("R7", 0);
    for (int i = 1; i <= 7; i++) begin
      one_tick();
      check_step("R9", (6 - (i % 6)) % 6);
    end
  endtask

  task automatic t_dir_frozen();
    do_reset(1'b1);
    one_tick();
    @(negedge clk); dir_fwd = 1'b0;
    one_tick();
    check_step("R10", 1);
    one_tick();
    check_step("R10", 2);
    dir_fwd = 1'b1;
  endtask

  task automatic t_held_tick();
    do_reset(1'b1);
    @(negedge clk); tick = 1'b1;
    @(negedge clk);
    check_step("R5", 0);
    @(negedge clk);
    @(negedge clk);
    check_step("R5", 0);
    tick = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check_step("R5", 0);
  endtask

  task automatic t_reset_midrun();
    do_reset(1'b1);
    one_tick(); one_tick(); one_tick();
    check_step("R8", 2);
    @(negedge clk); rst = 1'b1; tick = 1'b1;
    @(negedge clk);
    check_step("R6", 6);
    tick = 1'b0;
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check_step("R6", 6);
    one_tick();
    check_step("R7", 0);
  endtask

  initial begin
    t_reset_state();
    t_forward();
    t_reverse();
    t_dir_frozen();
    t_held_tick();
    t_reset_midrun();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule